// File: doc/BRIEF.md
# Two-Channel Indirect Register Port

This block sits between a host bus and the register file of a two-channel serial controller. The host sees one control port per channel. Every control-port write made while that channel's pointer is zero is taken as a command byte. Its low bits choose the register that the following control-port access will reach. Its middle field holds an operation code, and its top field holds a checksum/latch reset code. One of the operation codes raises the pointer into the upper half of the register space. After the host touches any register other than zero, the pointer falls back to zero.

The block stores the write registers and presents them on a flat bus for the datapath, interrupt and rate-generator blocks. Two write registers, the vector and the master-control register, are a single copy that both channels share. A shadow register can take the place of register 7 for writes, and a bit in each channel's register 15 enables that. Read accesses return stored values for the addresses that read back write registers. Channel-specific rules apply at addresses 2 and 3. Every other address is forwarded to an external status source. Operation and reset codes leave the block as one-cycle pulses, each tagged with the channel it was written on.

Top module: `ptr_regbank`

## Requirements
- R1: After reset, all stored write registers, both shadow registers and both pointers are zero, and neither `cmd_fire` nor `crc_fire` is high.
- R2: A control write while the channel's pointer is 0 loads the pointer with byte bits 2:0, so that the next access on that channel reaches that register. A read while the pointer is 0 returns external address 0 and leaves the pointer at 0.
- R3: When bits 5:3 of the command byte equal 1 (byte value 0x08 with the other bits clear), bit 3 of the pointer is set, so the next access reaches registers 8 to 15.
- R4: Any read or write on a channel whose pointer is non-zero returns that pointer to 0, so the next control write is decoded as a command.
- R5: Operation codes 2 to 7 in bits 5:3 of a command byte raise `cmd_fire` for exactly the cycle after the write, with `cmd_op` equal to the code and `cmd_ch` equal to the channel. Codes 0 (no-op) and 1 (point-high) produce no pulse.
- R6: Reset codes 1 to 3 in bits 7:6 of a command byte raise `crc_fire` for the cycle after the write, with `crc_op` equal to the code and `crc_ch` equal to the channel. Code 0 gives no pulse.
- R7: Write registers 2 and 9 are one copy. A write from either channel appears in both channel slots of `wr_regs`.
- R8: When bit 0 of a channel's register 15 is 1, a write to address 7 on that channel loads that channel's shadow register and leaves register 7 unchanged. When the bit is 0, the write goes to register 7.
- R9: Read addresses 12 and 13 return the stored low and high time-constant bytes, and read address 14 returns the channel's shadow register.
- R10: Read address 15 returns write register 15 with bits 0 and 2 cleared.
- R11: Read address 2 returns the shared vector register on channel 0 and external data on channel 1. Read address 3 returns external data on channel 0 and 0x00 on channel 1.
- R12: Every other read address returns `ext_rd_data`. During any read, `ext_rd_addr` and `ext_rd_chan` carry the current pointer and channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host control-port access this cycle |
| acc_chan | input | 1 | Channel of the access (0 or 1) |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational, valid during a read) |
| ext_rd_addr | output | 4 | Register address forwarded to the status source |
| ext_rd_chan | output | 1 | Channel forwarded to the status source |
| ext_rd_data | input | 8 | Status byte from the external source |
| wr_regs | output | 256 | Write registers, slot (ch*16+r) at bits 8*slot+7:8*slot, slot r=0 reads as zero |
| shadow_regs | output | 16 | Shadow register per channel, channel c at bits 8*c+7:8*c |
| cmd_fire | output | 1 | One-cycle operation pulse |
| cmd_op | output | 3 | Operation code of the pulse |
| cmd_ch | output | 1 | Channel of the operation pulse |
| crc_fire | output | 1 | One-cycle reset-code pulse |
| crc_op | output | 2 | Reset code of the pulse |
| crc_ch | output | 1 | Channel of the reset pulse |

## Verification
On every cycle, the assertions check the pointer rules (point-high sets the upper bit, and a non-zero access clears the pointer), the legality of pulse codes, the masking at read address 15, the zero at channel 1 address 3, the cross-channel copy of register 9 and the way the shadow enable protects register 7. Only the bench scenarios can show full data values. These are the complete contents of every stored register after sweeps on both channels, the exact pulse code and channel for all 32 command/reset combinations on each channel, and the forwarding of external status addresses. They also cover write-then-read sequences through the shadow register.

// File: rtl/ptr_regbank_pkg.sv
package ptr_regbank_pkg;
  localparam int NCH  = 2;
  localparam int DW   = 8;
  localparam int NREG = 16;
  localparam int AW   = $clog2(NREG);
  localparam int OPW  = 3;
  localparam int RCW  = 2;

  typedef logic [AW-1:0] regaddr_t;

  typedef enum logic [OPW-1:0] {
    OP_NONE      = 3'd0,
    OP_HIGH      = 3'd1,
    OP_CLR_EXT   = 3'd2,
    OP_ABORT     = 3'd3,
    OP_RX_NEXT   = 3'd4,
    OP_CLR_TXINT = 3'd5,
    OP_CLR_ERR   = 3'd6,
    OP_CLR_IUS   = 3'd7
  } op_e;

  localparam regaddr_t ADR_VEC    = 4'd2;
  localparam regaddr_t ADR_PEND   = 4'd3;
  localparam regaddr_t ADR_SEVEN  = 4'd7;
  localparam regaddr_t ADR_MASTER = 4'd9;
  localparam regaddr_t ADR_TCLO   = 4'd12;
  localparam regaddr_t ADR_TCHI   = 4'd13;
  localparam regaddr_t ADR_SHRD   = 4'd14;
  localparam regaddr_t ADR_XCTL   = 4'd15;
  localparam int       SHADOW_EN_BIT = 0;
  localparam logic [DW-1:0] XCTL_RD_MASK = 8'hFA;

  function automatic logic [OPW-1:0] byte_op(input logic [DW-1:0] b);
    return b[5:3];
  endfunction

  function automatic logic [RCW-1:0] byte_rc(input logic [DW-1:0] b);
    return b[7:6];
  endfunction

  function automatic regaddr_t next_ptr(input logic [DW-1:0] b);
    return {byte_op(b) == OP_HIGH, b[2:0]};
  endfunction

  function automatic logic op_pulses(input logic [OPW-1:0] op);
    return op > OP_HIGH;
  endfunction

  function automatic int slot_lsb(input int ch, input int r);
    return (ch * NREG + r) * DW;
  endfunction
endpackage

// File: rtl/ptr_regbank_track.sv
module ptr_regbank_track
  import ptr_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output regaddr_t      ptr_q,
  output logic          ctl_wr,
  output logic          reg_acc
);
  regaddr_t ptr_d;

  assign ctl_wr  = sel && wr && (ptr_q == '0);
  assign reg_acc = sel && (ptr_q != '0);

  always_comb begin
    ptr_d = ptr_q;
    if (ctl_wr)       ptr_d = next_ptr(wdata);
    else if (reg_acc) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/ptr_regbank_store.sv
module ptr_regbank_store
  import ptr_regbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     wch,
  input  regaddr_t                 waddr,
  input  logic [DW-1:0]            wdata,
  output logic [NCH*NREG*DW-1:0]   wr_flat,
  output logic [NCH*DW-1:0]        shadow_flat
);
  logic [DW-1:0] vec_q, master_q;
  logic [NCH-1:0] shadow_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= '0;
      master_q <= '0;
    end else if (we) begin
      if (waddr == ADR_VEC)    vec_q    <= wdata;
      if (waddr == ADR_MASTER) master_q <= wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          sh_hit;
    logic [DW-1:0] sh_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (r == 0) begin : g_zero
        assign wr_flat[slot_lsb(c, r) +: DW] = '0;
      end else if (r == int'(ADR_VEC)) begin : g_vec
        assign wr_flat[slot_lsb(c, r) +: DW] = vec_q;
      end else if (r == int'(ADR_MASTER)) begin : g_mst
        assign wr_flat[slot_lsb(c, r) +: DW] = master_q;
      end else begin : g_own
        logic          hit;
        logic [DW-1:0] q;
        assign hit = we && (wch == 1'(c)) && (waddr == AW'(r)) &&
                     !((r == int'(ADR_SEVEN)) && shadow_en[c]);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= '0;
          else if (hit) q <= wdata;
        end
        assign wr_flat[slot_lsb(c, r) +: DW] = q;
      end
    end

    assign shadow_en[c] = wr_flat[slot_lsb(c, int'(ADR_XCTL)) + SHADOW_EN_BIT];
    assign sh_hit = we && (wch == 1'(c)) && (waddr == ADR_SEVEN) && shadow_en[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (sh_hit) sh_q <= wdata;
    end
    assign shadow_flat[c*DW +: DW] = sh_q;
  end
endmodule

// File: rtl/ptr_regbank_rdmux.sv
module ptr_regbank_rdmux
  import ptr_regbank_pkg::*;
(
  input  logic                   chan,
  input  regaddr_t               addr,
  input  logic [NCH*NREG*DW-1:0] wr_flat,
  input  logic [NCH*DW-1:0]      shadow_flat,
  input  logic [DW-1:0]          ext_data,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] stored;
  logic [DW-1:0] shadow;

  assign stored = wr_flat[int'({chan, addr}) * DW +: DW];
  assign shadow = shadow_flat[int'(chan) * DW +: DW];

  always_comb begin
    unique case (addr)
      ADR_VEC:          rdata = chan ? ext_data : stored;
      ADR_PEND:         rdata = chan ? '0 : ext_data;
      ADR_TCLO, ADR_TCHI: rdata = stored;
      ADR_SHRD:         rdata = shadow;
      ADR_XCTL:         rdata = stored & XCTL_RD_MASK;
      default:          rdata = ext_data;
    endcase
  end
endmodule

// File: rtl/ptr_regbank.sv
module ptr_regbank
  import ptr_regbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic                   acc_chan,
  input  logic                   acc_wr,
  input  logic [DW-1:0]          acc_wdata,
  output logic [DW-1:0]          acc_rdata,
  output logic [AW-1:0]          ext_rd_addr,
  output logic                   ext_rd_chan,
  input  logic [DW-1:0]          ext_rd_data,
  output logic [NCH*NREG*DW-1:0] wr_regs,
  output logic [NCH*DW-1:0]      shadow_regs,
  output logic                   cmd_fire,
  output logic [OPW-1:0]         cmd_op,
  output logic                   cmd_ch,
  output logic                   crc_fire,
  output logic [RCW-1:0]         crc_op,
  output logic                   crc_ch
);
  regaddr_t       ptr_q  [NCH];
  logic [NCH-1:0] ctl_wr_c;
  logic [NCH-1:0] reg_acc_c;

  for (genvar c = 0; c < NCH; c++) begin : g_trk
    ptr_regbank_track u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (acc_valid && (acc_chan == 1'(c))),
      .wr      (acc_wr),
      .wdata   (acc_wdata),
      .ptr_q   (ptr_q[c]),
      .ctl_wr  (ctl_wr_c[c]),
      .reg_acc (reg_acc_c[c])
    );
  end

  // Named internal events, observed by the checker.
  regaddr_t ptr_a, ptr_b, acc_addr;
  logic     ctl_wr_evt, data_wr_evt, rd_evt;
  logic     op_evt, rc_evt;

  assign ptr_a       = ptr_q[0];
  assign ptr_b       = ptr_q[1];
  assign acc_addr    = ptr_q[acc_chan];
  assign ctl_wr_evt  = |ctl_wr_c;
  assign data_wr_evt = (|reg_acc_c) && acc_wr;
  assign rd_evt      = acc_valid && !acc_wr;
  assign op_evt      = ctl_wr_evt && op_pulses(byte_op(acc_wdata));
  assign rc_evt      = ctl_wr_evt && (byte_rc(acc_wdata) != '0);

  ptr_regbank_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (data_wr_evt),
    .wch         (acc_chan),
    .waddr       (acc_addr),
    .wdata       (acc_wdata),
    .wr_flat     (wr_regs),
    .shadow_flat (shadow_regs)
  );

  ptr_regbank_rdmux u_rd (
    .chan        (acc_chan),
    .addr        (acc_addr),
    .wr_flat     (wr_regs),
    .shadow_flat (shadow_regs),
    .ext_data    (ext_rd_data),
    .rdata       (acc_rdata)
  );

  assign ext_rd_addr = acc_addr;
  assign ext_rd_chan = acc_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_fire <= 1'b0;
      cmd_op   <= '0;
      cmd_ch   <= 1'b0;
      crc_fire <= 1'b0;
      crc_op   <= '0;
      crc_ch   <= 1'b0;
    end else begin
      cmd_fire <= op_evt;
      cmd_op   <= op_evt ? byte_op(acc_wdata) : '0;
      cmd_ch   <= op_evt && acc_chan;
      crc_fire <= rc_evt;
      crc_op   <= rc_evt ? byte_rc(acc_wdata) : '0;
      crc_ch   <= rc_evt && acc_chan;
    end
  end
endmodule

// File: rtl/ptr_regbank_chk.sv
module ptr_regbank_chk
  import ptr_regbank_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   acc_chan,
  input logic                   acc_wr,
  input logic [DW-1:0]          acc_wdata,
  input logic [DW-1:0]          acc_rdata,
  input logic [NCH*NREG*DW-1:0] wr_regs,
  input logic                   cmd_fire,
  input logic [OPW-1:0]         cmd_op,
  input logic                   crc_fire,
  input logic [RCW-1:0]         crc_op,
  input regaddr_t               ptr_a,
  input regaddr_t               ptr_b,
  input regaddr_t               acc_addr,
  input logic                   data_wr_evt
);
  localparam int L7A  = slot_lsb(0, 7);
  localparam int L7B  = slot_lsb(1, 7);
  localparam int L15A = slot_lsb(0, 15);
  localparam int L15B = slot_lsb(1, 15);
  localparam int L9A  = slot_lsb(0, 9);

  assert_point_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr && !acc_chan && ptr_a == '0 && acc_wdata[5:3] == 3'd1) |=> ptr_a[3]);

  assert_ptr_return_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_chan && ptr_a != '0) |=> (ptr_a == '0));

  assert_ptr_return_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_chan && ptr_b != '0) |=> (ptr_b == '0));

  assert_read_keeps_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_wr && !acc_chan && ptr_a == '0) |=> (ptr_a == '0));

  assert_op_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (cmd_op > 3'd1 && $past(acc_valid && acc_wr)));

  assert_rc_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_fire |-> (crc_op != 2'd0 && $past(acc_valid && acc_wr)));

  assert_shared_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_evt && acc_chan && acc_addr == 4'd9) |=> (wr_regs[L9A +: DW] == $past(acc_wdata)));

  assert_shadow_guard_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_evt && !acc_chan && acc_addr == 4'd7 && wr_regs[L15A]) |=> $stable(wr_regs[L7A +: DW]));

  assert_shadow_guard_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_evt && acc_chan && acc_addr == 4'd7 && wr_regs[L15B]) |=> $stable(wr_regs[L7B +: DW]));

  always_comb begin
    if (rst_n && acc_valid && !acc_wr && acc_addr == 4'd15)
      assert_xctl_mask_R10: assert (acc_rdata[0] == 1'b0 && acc_rdata[2] == 1'b0);
    if (rst_n && acc_valid && !acc_wr && acc_chan && acc_addr == 4'd3)
      assert_pend_b_zero_R11: assert (acc_rdata == '0);
  end
endmodule

bind ptr_regbank ptr_regbank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_chan    (acc_chan),
  .acc_wr      (acc_wr),
  .acc_wdata   (acc_wdata),
  .acc_rdata   (acc_rdata),
  .wr_regs     (wr_regs),
  .cmd_fire    (cmd_fire),
  .cmd_op      (cmd_op),
  .crc_fire    (crc_fire),
  .crc_op      (crc_op),
  .ptr_a       (ptr_a),
  .ptr_b       (ptr_b),
  .acc_addr    (acc_addr),
  .data_wr_evt (data_wr_evt)
);

// File: tb/sim_ptr_regbank.sv
module sim_ptr_regbank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0;
  logic         acc_chan = 1'b0;
  logic         acc_wr = 1'b0;
  logic [7:0]   acc_wdata = '0;
  logic [7:0]   acc_rdata;
  logic [3:0]   ext_rd_addr;
  logic         ext_rd_chan;
  logic [7:0]   ext_rd_data;
  logic [255:0] wr_regs;
  logic [15:0]  shadow_regs;
  logic         cmd_fire, cmd_ch, crc_fire, crc_ch;
  logic [2:0]   cmd_op;
  logic [1:0]   crc_op;

  int errors = 0;
  int checks = 0;

  logic [7:0] mw [2][16];
  logic [7:0] msh [2];
  logic [7:0] got_rd;
  logic [3:0] got_addr;
  logic       got_chan;

  always #10 clk = ~clk;

  assign ext_rd_data = {ext_rd_chan, 3'b101, ext_rd_addr};

  ptr_regbank u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_chan(acc_chan),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ext_rd_addr(ext_rd_addr), .ext_rd_chan(ext_rd_chan), .ext_rd_data(ext_rd_data),
    .wr_regs(wr_regs), .shadow_regs(shadow_regs),
    .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
    .crc_fire(crc_fire), .crc_op(crc_op), .crc_ch(crc_ch)
  );

  function automatic logic [7:0] ext_of(input int ch, input int a);
    return 8'((ch << 7) | (5 << 4) | a);
  endfunction

  function automatic logic [7:0] exp_read(input int ch, input int a);
    case (a)
      2:       return ch == 1 ? ext_of(ch, a) : mw[0][2];
      3:       return ch == 1 ? 8'h00 : ext_of(ch, a);
      12, 13:  return mw[ch][a];
      14:      return msh[ch];
      15:      return mw[ch][15] & ~8'h05;
      default: return ext_of(ch, a);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input int ch, input logic wr, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_chan  = 1'(ch);
    acc_wr    = wr;
    acc_wdata = d;
    #5;
    got_rd   = acc_rdata;
    got_addr = ext_rd_addr;
    got_chan = ext_rd_chan;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_wr    = 1'b0;
  endtask

  task automatic model_write(input int ch, input int a, input logic [7:0] v);
    if (a == 2 || a == 9) begin
      mw[0][a] = v;
      mw[1][a] = v;
    end else if (a == 7 && mw[ch][15][0]) begin
      msh[ch] = v;
    end else begin
      mw[ch][a] = v;
    end
  endtask

  task automatic set_reg(input int ch, input int a, input logic [7:0] v);
    access(ch, 1'b1, a < 8 ? 8'(a) : 8'(8 | (a - 8)));
    check("R5 no pulse for pointer-only byte", {31'd0, cmd_fire}, 32'd0);
    access(ch, 1'b1, v);
    model_write(ch, a, v);
  endtask

  task automatic read_reg(input int ch, input int a, input string req);
    access(ch, 1'b1, a < 8 ? 8'(a) : 8'(8 | (a - 8)));
    access(ch, 1'b0, 8'h00);
    check(req, {24'd0, got_rd}, {24'd0, exp_read(ch, a)});
    check("R12 forwarded address", {27'd0, got_chan, got_addr}, 32'(ch * 16 + a));
  endtask

  task automatic compare_all(input string req);
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 16; r++)
        check(req, {24'd0, wr_regs[(c*16+r)*8 +: 8]}, {24'd0, mw[c][r]});
      check(req, {24'd0, shadow_regs[c*8 +: 8]}, {24'd0, msh[c]});
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      msh[c] = '0;
      for (int r = 0; r < 16; r++) mw[c][r] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wr_regs zero", {31'd0, |wr_regs}, 32'd0);
    check("R1 shadow zero", {16'd0, shadow_regs}, 32'd0);
    check("R1 no pulses", {30'd0, cmd_fire, crc_fire}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: read with pointer at zero hits external address 0 and stays there
    access(0, 1'b0, 8'h00);
    check("R2 read at zero", {24'd0, got_rd}, {24'd0, ext_of(0, 0)});
    access(0, 1'b0, 8'h00);
    check("R2 pointer stays zero", {28'd0, got_addr}, 32'd0);

    // R2 R3 R7: sweep every register on both channels
    for (int c = 0; c < 2; c++)
      for (int r = 1; r < 16; r++)
        set_reg(c, r, 8'((c * 16 + r) * 7 + 3));
    compare_all("R2 R3 R7 register sweep");
    check("R7 shared vector", {24'd0, wr_regs[2*8 +: 8]}, {24'd0, wr_regs[18*8 +: 8]});

    // R4: after a data write the next control write is a command
    set_reg(1, 5, 8'h3C);
    access(1, 1'b1, 8'h10);
    check("R4 pointer back to zero", {27'd0, cmd_fire, cmd_op, cmd_ch}, {27'd0, 1'b1, 3'd2, 1'b1});

    // R9 R11 R12: read map on both channels
    for (int c = 0; c < 2; c++) begin
      read_reg(c, 2, "R11 address 2");
      read_reg(c, 3, "R11 address 3");
      read_reg(c, 12, "R9 time constant low");
      read_reg(c, 13, "R9 time constant high");
      read_reg(c, 1, "R12 external address 1");
      read_reg(c, 8, "R12 external address 8");
      read_reg(c, 10, "R12 external address 10");
      read_reg(c, 15, "R10 address 15");
    end

    // R8: shadow enable routes address 7
    set_reg(0, 15, 8'h01);
    set_reg(0, 7, 8'h5A);
    compare_all("R8 shadow write");
    read_reg(0, 14, "R9 shadow readback");
    read_reg(0, 15, "R10 mask bit 0");
    set_reg(0, 15, 8'hFF);
    read_reg(0, 15, "R10 mask bits 0 and 2");
    set_reg(1, 7, 8'hC3);
    compare_all("R8 disabled channel writes register 7");
    set_reg(0, 15, 8'h00);
    set_reg(0, 7, 8'h66);
    compare_all("R8 enable cleared");

    // R5 R6 R3: every operation/reset code on both channels
    for (int c = 0; c < 2; c++)
      for (int op = 0; op < 8; op++)
        for (int rc = 0; rc < 4; rc++) begin
          access(c, 1'b1, 8'((rc << 6) | (op << 3)));
          if (op > 1)
            check("R5 operation pulse", {27'd0, cmd_fire, cmd_op, cmd_ch}, {27'd0, 1'b1, 3'(op), 1'(c)});
          else
            check("R5 no operation pulse", {27'd0, cmd_fire, cmd_op, cmd_ch}, 32'd0);
          if (rc > 0)
            check("R6 reset pulse", {28'd0, crc_fire, crc_op, crc_ch}, {28'd0, 1'b1, 2'(rc), 1'(c)});
          else
            check("R6 no reset pulse", {28'd0, crc_fire, crc_op, crc_ch}, 32'd0);
          @(negedge clk);
          check("R5 pulse lasts one cycle", {30'd0, cmd_fire, crc_fire}, 32'd0);
          if (op == 1) begin
            access(c, 1'b0, 8'h00);
            check("R3 point-high reaches 8", {24'd0, got_rd}, {24'd0, ext_of(c, 8)});
          end
        end
    compare_all("R5 commands leave registers");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule